// File: doc/BRIEF.md
# Subdetector Event Timestamp Unit

This block sits in a detector front end and keeps the local notion of time. It runs one combined time counter at the fine-step rate: the low 8 bits are the fine time, with 256 steps per coarse tick. The upper 24 bits are the coarse timestamp, so the coarse value advances once for every full cycle of fine steps. A trigger strobe comes with a 6-bit message code. When the code asks for a counter restart, both parts of the counter return to zero on the edge that samples the strobe. Every detector in the system does this at the moment the same strobe reaches it, so their counters stay aligned.

The block continuously rebases the local (coarse, fine) time into a reference identifier by subtracting a signed inter-detector offset. The subtraction is done on the combined value, so a fine-time underflow borrows from the coarse part. Each ordinary strobe yields a trigger-event record two cycles later. The record holds the rebased coarse time minus a fixed trigger latency, the rebased fine time, and the message code. The offset and the latency are configuration inputs that the surrounding logic holds steady; a counter restart does not touch them.

Top module: `evt_stamp_unit`

## Requirements
- R1: While reset is asserted, the coarse and fine counters read 0, the reference identifier is 0 minus the offset, and the record valid output is 0.
- R2: Outside a restart, the combined counter (coarse × 256 + fine, coarse in the upper 24 bits and fine in the low 8 bits) advances by one each clock, so coarse increments when fine wraps from 255 to 0.
- R3: A strobe sampled with message code 6'h01 clears both coarse and fine at that edge; the counter reads 0 in the next cycle and counts on from there.
- R4: The reference identifier is (combined counter − offset) modulo 2^32, with the offset read as a signed 32-bit value. The reference coarse is its upper 24 bits and the reference fine is its low 8 bits, so a negative fine difference borrows from coarse. This holds immediately after a restart too.
- R5: A strobe whose code is not 6'h01 raises the record valid output for exactly one cycle, two cycles after the cycle in which the strobe was sampled.
- R6: The record carries (reference coarse at the strobe − latency) modulo 2^24, the reference fine at the strobe, and the strobe's message code.
- R7: A strobe with code 6'h01 produces no record.
- R8: Strobes in consecutive cycles each produce their own record, in order. A restart strobe that directly follows an ordinary strobe still lets that earlier record appear with its pre-restart values, in the same cycle as the counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine-step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger strobe, one cycle per trigger |
| msg_i | input | 6 | Message code sampled with the strobe |
| cfg_delta_i | input | 32 | Signed inter-detector offset, in fine steps |
| cfg_lat_i | input | 24 | Trigger latency, in coarse ticks |
| ts_coarse_o | output | 24 | Local coarse timestamp |
| ts_fine_o | output | 8 | Local fine time |
| ref_coarse_o | output | 24 | Rebased coarse time |
| ref_fine_o | output | 8 | Rebased fine time |
| rec_valid_o | output | 1 | One-cycle pulse marking a trigger-event record |
| rec_coarse_o | output | 24 | Record reference coarse timestamp |
| rec_fine_o | output | 8 | Record reference fine time |
| rec_msg_o | output | 6 | Record message code |

## Verification
Two functions can fall in the same cycle: a record emerging from the two-stage pipe, and a counter restart. The bench provokes this with an ordinary strobe followed directly by a restart strobe. In the cycle after the restart edge, it requires both that the counters read zero and that the record shows the values captured before the restart. Back-to-back ordinary strobes are also driven, to show that records neither merge nor drop.

// File: rtl/evts_pkg.sv
package evts_pkg;
   localparam int unsigned COARSE_W_DEF = 24;
   localparam int unsigned FINE_W_DEF   = 8;
   localparam int unsigned MSG_W_DEF    = 6;
   localparam int unsigned CLR_CODE_DEF = 1;

   function automatic logic is_clear_code(input logic [31:0] code, input logic [31:0] clr_code);
      return code == clr_code;
   endfunction
endpackage

// File: rtl/evts_counter.sv
module evts_counter #(
   parameter int unsigned COARSE_W = 24,
   parameter int unsigned FINE_W   = 8,
   localparam int unsigned ID_W    = COARSE_W + FINE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   output logic [ID_W-1:0] cnt_o
);
   logic [ID_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + ID_W'(1);
   end

   assign cnt_o = cnt_q;

   // R2: coarse steps exactly when fine wraps
   p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && (&cnt_q[FINE_W-1:0])) |=>
         (cnt_q[FINE_W-1:0] == '0) &&
         (cnt_q[ID_W-1:FINE_W] == COARSE_W'($past(cnt_q[ID_W-1:FINE_W]) + COARSE_W'(1))));

   // R2: coarse holds while fine has not wrapped
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !(&cnt_q[FINE_W-1:0])) |=> $stable(cnt_q[ID_W-1:FINE_W]));
endmodule

// File: rtl/evts_rebase.sv
module evts_rebase #(
   parameter int unsigned COARSE_W = 24,
   parameter int unsigned FINE_W   = 8,
   localparam int unsigned ID_W    = COARSE_W + FINE_W
) (
   input  logic [ID_W-1:0]     local_i,
   input  logic [ID_W-1:0]     delta_i,
   output logic [COARSE_W-1:0] ref_coarse_o,
   output logic [FINE_W-1:0]   ref_fine_o
);
   logic [ID_W-1:0] diff;

   // two's-complement subtraction covers a signed offset and the fine-to-coarse borrow
   assign diff         = local_i - delta_i;
   assign ref_coarse_o = diff[ID_W-1:FINE_W];
   assign ref_fine_o   = diff[FINE_W-1:0];
endmodule

// File: rtl/evts_record.sv
module evts_record #(
   parameter int unsigned COARSE_W = 24,
   parameter int unsigned FINE_W   = 8,
   parameter int unsigned MSG_W    = 6,
   localparam int unsigned ID_W    = COARSE_W + FINE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  logic [ID_W-1:0]     ref_i,
   input  logic [MSG_W-1:0]    msg_i,
   input  logic [COARSE_W-1:0] lat_i,
   output logic                rec_valid_o,
   output logic [COARSE_W-1:0] rec_coarse_o,
   output logic [FINE_W-1:0]   rec_fine_o,
   output logic [MSG_W-1:0]    rec_msg_o
);
   logic             s1_v;
   logic [ID_W-1:0]  s1_ref;
   logic [MSG_W-1:0] s1_msg;

   // stage 1: capture the rebased time of the strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v   <= 1'b0;
         s1_ref <= '0;
         s1_msg <= '0;
      end else begin
         s1_v <= take_i;
         if (take_i) begin
            s1_ref <= ref_i;
            s1_msg <= msg_i;
         end
      end
   end

   // stage 2: remove the trigger latency from the coarse part
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_valid_o  <= 1'b0;
         rec_coarse_o <= '0;
         rec_fine_o   <= '0;
         rec_msg_o    <= '0;
      end else begin
         rec_valid_o <= s1_v;
         if (s1_v) begin
            rec_coarse_o <= s1_ref[ID_W-1:FINE_W] - lat_i;
            rec_fine_o   <= s1_ref[FINE_W-1:0];
            rec_msg_o    <= s1_msg;
         end
      end
   end

   // R5: record appears two cycles after an accepted strobe
   p_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> ##1 rec_valid_o);

   // R5: no record without a strobe two cycles earlier
   p_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> $past(take_i, 2));

   // R6: record fine time is the rebased fine time at the strobe
   p_fine_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> rec_fine_o == $past(ref_i[FINE_W-1:0], 2));
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
   import evts_pkg::*;
#(
   parameter int unsigned COARSE_W = COARSE_W_DEF,
   parameter int unsigned FINE_W   = FINE_W_DEF,
   parameter int unsigned MSG_W    = MSG_W_DEF,
   parameter int unsigned CLR_CODE = CLR_CODE_DEF,
   localparam int unsigned ID_W    = COARSE_W + FINE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_i,
   input  logic [MSG_W-1:0]    msg_i,
   input  logic [ID_W-1:0]     cfg_delta_i,
   input  logic [COARSE_W-1:0] cfg_lat_i,
   output logic [COARSE_W-1:0] ts_coarse_o,
   output logic [FINE_W-1:0]   ts_fine_o,
   output logic [COARSE_W-1:0] ref_coarse_o,
   output logic [FINE_W-1:0]   ref_fine_o,
   output logic                rec_valid_o,
   output logic [COARSE_W-1:0] rec_coarse_o,
   output logic [FINE_W-1:0]   rec_fine_o,
   output logic [MSG_W-1:0]    rec_msg_o
);
   generate
      if (FINE_W < 1 || COARSE_W < 2 || ID_W > 32) begin : g_bad_width
         $error("evt_stamp_unit: counter widths out of range");
      end
      if (MSG_W < 1 || MSG_W > 32 || CLR_CODE >= (1 << MSG_W)) begin : g_bad_code
         $error("evt_stamp_unit: restart code does not fit the message field");
      end
   endgenerate

   logic            code_clr;
   logic            clr;
   logic            take;
   logic [ID_W-1:0] cnt;

   assign code_clr = is_clear_code(32'(msg_i), 32'(CLR_CODE));
   assign clr      = trig_i && code_clr;
   assign take     = trig_i && !code_clr;

   evts_counter #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .cnt_o (cnt)
   );

   assign ts_coarse_o = cnt[ID_W-1:FINE_W];
   assign ts_fine_o   = cnt[FINE_W-1:0];

   evts_rebase #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_rebase (
      .local_i      (cnt),
      .delta_i      (cfg_delta_i),
      .ref_coarse_o (ref_coarse_o),
      .ref_fine_o   (ref_fine_o)
   );

   evts_record #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .MSG_W(MSG_W)) u_rec (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .ref_i        ({ref_coarse_o, ref_fine_o}),
      .msg_i        (msg_i),
      .lat_i        (cfg_lat_i),
      .rec_valid_o  (rec_valid_o),
      .rec_coarse_o (rec_coarse_o),
      .rec_fine_o   (rec_fine_o),
      .rec_msg_o    (rec_msg_o)
   );

   // R3: restart strobe zeroes both counters at its edge
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && msg_i == MSG_W'(CLR_CODE)) |=> (ts_coarse_o == '0) && (ts_fine_o == '0));

   // R7: restart strobe never yields a record
   p_norec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && msg_i == MSG_W'(CLR_CODE)) |=> ##1 !rec_valid_o);

   // R4: rebased identifier plus offset gives back the local time
   p_rebase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ID_W'({ref_coarse_o, ref_fine_o} + cfg_delta_i) == {ts_coarse_o, ts_fine_o});

   // R5: record valid is a single-cycle pulse unless strobes are back to back
   p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_o && !$past(take)) |=> !rec_valid_o);
endmodule

// File: tb/evt_stamp_unit_tb_top.sv
`timescale 1ns/1ps
module evt_stamp_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        trig;
   logic [5:0]  msg;
   logic [31:0] delta;
   logic [23:0] lat;
   logic [23:0] ts_coarse, ref_coarse, rec_coarse;
   logic [7:0]  ts_fine, ref_fine, rec_fine;
   logic        rec_valid;
   logic [5:0]  rec_msg;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   evt_stamp_unit dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .msg_i(msg),
      .cfg_delta_i(delta), .cfg_lat_i(lat),
      .ts_coarse_o(ts_coarse), .ts_fine_o(ts_fine),
      .ref_coarse_o(ref_coarse), .ref_fine_o(ref_fine),
      .rec_valid_o(rec_valid), .rec_coarse_o(rec_coarse),
      .rec_fine_o(rec_fine), .rec_msg_o(rec_msg)
   );

   // wait {16}, msg {6}, offset {32}, latency {24}
   localparam int NV = 8;
   localparam logic [77:0] VEC [0:NV-1] = '{
      {16'd5,    6'h02, 32'h0000_0000, 24'h000000},
      {16'd300,  6'h3F, 32'h0000_0100, 24'h000001},
      {16'd10,   6'h00, 32'h0000_0014, 24'h000000},
      {16'd700,  6'h2A, 32'hFFFF_FED4, 24'h000005},
      {16'd256,  6'h10, 32'h0000_0001, 24'h000000},
      {16'd1000, 6'h3E, 32'h0000_0400, 24'h000003},
      {16'd0,    6'h04, 32'h0000_0000, 24'hFFFFFF},
      {16'd513,  6'h07, 32'h7FFF_FFFF, 24'h000000}
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic restart();
      trig = 1'b1; msg = 6'h01;
      tick();
      trig = 1'b0; msg = 6'h00;
   endtask

   function automatic logic [31:0] exp_ref(input logic [31:0] local_t, input logic [31:0] d);
      return local_t - d;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; trig = 1'b0; msg = 6'h00; delta = 32'd9; lat = 24'd0;
      @(negedge clk);
      repeat (3) tick();
      // R1 reset state
      chk("R1", "coarse", 32'(ts_coarse), 32'd0);
      chk("R1", "fine", 32'(ts_fine), 32'd0);
      chk("R1", "ref", {ref_coarse, ref_fine}, exp_ref(32'd0, 32'd9));
      chk("R1", "rec_valid", 32'(rec_valid), 32'd0);

      rst_n = 1'b1;
      delta = 32'd0;
      tick();
      chk("R2", "fine after one clock", {ts_coarse, ts_fine}, 32'd1);

      // R3 restart, then R2 carry into coarse
      restart();
      chk("R3", "counter after restart", {ts_coarse, ts_fine}, 32'd0);
      tick();
      chk("R3", "counts on after restart", {ts_coarse, ts_fine}, 32'd1);
      restart();
      repeat (300) tick();
      chk("R2", "coarse after carry", 32'(ts_coarse), 32'd1);
      chk("R2", "fine after carry", 32'(ts_fine), 32'd44);

      // R4 offset survives a restart, negative result borrows
      delta = 32'd7;
      restart();
      chk("R4", "ref coarse after restart", 32'(ref_coarse), 32'h00FF_FFFF);
      chk("R4", "ref fine after restart", 32'(ref_fine), 32'h0000_00F9);

      // table walk: R4, R5, R6
      for (int i = 0; i < NV; i++) begin
         logic [15:0] w;
         logic [5:0]  m;
         logic [31:0] r;
         w = VEC[i][77:62]; m = VEC[i][61:56];
         delta = VEC[i][55:24]; lat = VEC[i][23:0];
         restart();
         repeat (int'(w)) tick();
         r = exp_ref(32'(w), delta);
         chk("R4", "ref id before strobe", {ref_coarse, ref_fine}, r);
         trig = 1'b1; msg = m;
         tick();
         trig = 1'b0; msg = 6'h00;
         chk("R5", "no early record", 32'(rec_valid), 32'd0);
         tick();
         chk("R5", "record valid", 32'(rec_valid), 32'd1);
         chk("R6", "record coarse", 32'(rec_coarse), 32'(24'(r[31:8] - lat)));
         chk("R6", "record fine", 32'(rec_fine), 32'(r[7:0]));
         chk("R6", "record msg", 32'(rec_msg), 32'(m));
         tick();
         chk("R5", "record one cycle", 32'(rec_valid), 32'd0);
      end

      // R7 restart strobe produces no record
      delta = 32'd0; lat = 24'd0;
      restart();
      chk("R7", "no record cycle 1", 32'(rec_valid), 32'd0);
      tick();
      chk("R7", "no record cycle 2", 32'(rec_valid), 32'd0);
      tick();
      chk("R7", "no record cycle 3", 32'(rec_valid), 32'd0);

      // R8 ordinary strobe directly followed by a restart strobe
      restart();
      repeat (20) tick();
      trig = 1'b1; msg = 6'h05;
      tick();
      msg = 6'h01;
      tick();
      trig = 1'b0; msg = 6'h00;
      chk("R8", "record during restart valid", 32'(rec_valid), 32'd1);
      chk("R8", "record keeps pre-restart fine", 32'(rec_fine), 32'd20);
      chk("R8", "record msg", 32'(rec_msg), 32'h05);
      chk("R8", "counter zero in same cycle", {ts_coarse, ts_fine}, 32'd0);
      tick();
      chk("R8", "restart adds no record", 32'(rec_valid), 32'd0);
      chk("R8", "counter counts on", {ts_coarse, ts_fine}, 32'd1);

      // R8 back-to-back ordinary strobes
      restart();
      repeat (4) tick();
      trig = 1'b1; msg = 6'h02;
      tick();
      msg = 6'h03;
      tick();
      trig = 1'b0; msg = 6'h00;
      chk("R8", "first record valid", 32'(rec_valid), 32'd1);
      chk("R8", "first record fine", 32'(rec_fine), 32'd4);
      chk("R8", "first record msg", 32'(rec_msg), 32'h02);
      tick();
      chk("R8", "second record valid", 32'(rec_valid), 32'd1);
      chk("R8", "second record fine", 32'(rec_fine), 32'd5);
      chk("R8", "second record msg", 32'(rec_msg), 32'h03);
      tick();
      chk("R8", "records end", 32'(rec_valid), 32'd0);

      finish_run();
   end
endmodule